// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a programmable sum-of-products logic device. A vector of product terms from the AND plane enters the cell. The cell ORs those terms. It can apply an output inversion, and it then either registers the result or passes it straight through. The result goes to a tri-state pin driver. The cell also returns one feedback signal to the AND plane.

A three-bit control word selects one of four operating modes: registered output, combinatorial output, combinatorial I/O, or dedicated input. Two bits of the word are shared by every cell of the device and one bit belongs to the cell. The word also sets where the feedback comes from and which signal enables the pin driver.

The state register has a preload path, so a test can force any state into it, including states the logic cannot reach. On reset the register clears, which makes the pin read high under either polarity. A parameter marks the cell as one of the restricted positions. In a restricted cell, combinatorial output mode gives no feedback and the dedicated-input mode is not available.

Top module: `sop_out_cell`

## Requirements
- R1: While `rst_n` is low the register clears asynchronously and holds. In registered mode `pin_out` then reads 1 whatever `out_inv` is.
- R2: Mode decode, with `glb_mode` as {shared bit B, shared bit A} and `cell_mode` as the local bit L. B=1,A=0,L=0 gives registered. B=1,A=0,L=1 gives combinatorial I/O. B=1,A=1,L=0 gives combinatorial I/O. B=1,A=1,L=1 gives dedicated input. B=0,A=1,L=1 gives dedicated input. Every other code gives combinatorial output.
- R3: In registered mode, `pin_out` after each rising clock edge equals (OR of all of `pterm`) XOR `out_inv`, sampled at that edge. `out_inv`=1 means active-low.
- R4: In registered mode `pin_oe` equals NOT `oe_n`. `fb` equals the registered pin level, whether or not the driver is enabled.
- R5: When `preload_en` is high at a rising edge, the register is loaded so that `pin_out` in registered mode shows `preload_val`. This overrides the logic value.
- R6: In combinatorial output mode `pin_out` is (OR of all terms) XOR `out_inv` in the same cycle, and `pin_oe` is 1. `fb` equals `pin_out`.
- R7: In combinatorial I/O mode, `pterm[0]` drives `pin_oe`. `pin_out` is (OR of `pterm[NUM_TERMS-1:1]`) XOR `out_inv`, and `fb` equals `pin_in`.
- R8: In dedicated input mode `pin_oe` is 0, `pin_out` is 0 and `fb` equals `pin_in`.
- R9: In a cell built with `RESTRICTED`=1, combinatorial output mode drives `fb` to 0. Any dedicated-input code decodes as combinatorial output instead.
- R10: `ctl_pins_free` is 0 exactly when `glb_mode` is 2'b10, which is the register group. Otherwise it is 1, meaning the clock and enable pins may serve as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous power-up clear |
| pterm | input | NUM_TERMS | Product terms from the AND plane |
| oe_n | input | 1 | Active-low global driver enable |
| glb_mode | input | 2 | Shared mode bits {B, A} |
| cell_mode | input | 1 | Local mode bit L |
| out_inv | input | 1 | 1 selects active-low output |
| preload_en | input | 1 | Synchronous register preload strobe |
| preload_val | input | 1 | Pin level to preload |
| pin_in | input | 1 | Level seen on the pad |
| pin_out | output | 1 | Value toward the pad driver |
| pin_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback to the AND plane |
| ctl_pins_free | output | 1 | Clock/enable pins usable as data |

## Verification
The bench checks that reset makes the pin read high under both polarities. A design that stored the pin level directly, instead of its complement, would read low there. It drives a preload against logic that wants the opposite value, so a design that gave the next-state logic priority shows up at once. In combinatorial I/O mode it uses a pattern where only term 0 is set, which catches a design that lets the enable term leak into the data sum. A second, restricted instance runs the same stimulus, which exposes any feedback in its combinatorial output mode and any dedicated-input code it still honours.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

   typedef enum logic [1:0] {
      CM_REG      = 2'd0,
      CM_COMB_OUT = 2'd1,
      CM_COMB_IO  = 2'd2,
      CM_DED_IN   = 2'd3
   } cell_mode_e;

   localparam int MIN_TERMS = 2;
   localparam int MAX_TERMS = 64;

   // glb[1] = shared bit B, glb[0] = shared bit A, loc = local bit L
   function automatic cell_mode_e decode_mode(input logic [1:0] glb, input logic loc);
      cell_mode_e m;
      unique case (glb)
         2'b10:   m = loc ? CM_COMB_IO : CM_REG;
         2'b11:   m = loc ? CM_DED_IN  : CM_COMB_IO;
         2'b01:   m = loc ? CM_DED_IN  : CM_COMB_OUT;
         default: m = CM_COMB_OUT;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/sop_term_sum.sv
module sop_term_sum #(
   parameter int NUM_TERMS = 8
) (
   input  logic [NUM_TERMS-1:0] pterm,
   output logic                 sum_all,
   output logic                 sum_data,
   output logic                 en_term
);
   localparam int DATA_TERMS = NUM_TERMS - 1;

   logic [DATA_TERMS-1:0] data_terms;

   assign data_terms = pterm[NUM_TERMS-1:1];
   assign en_term    = pterm[0];
   assign sum_data   = |data_terms;
   assign sum_all    = sum_data | en_term;
endmodule

// File: rtl/sop_mode_dec.sv
module sop_mode_dec
   import sop_cell_pkg::*;
#(
   parameter bit RESTRICTED = 1'b0
) (
   input  logic [1:0] glb_mode,
   input  logic       cell_mode,
   output cell_mode_e mode,
   output logic       ctl_pins_free
);
   cell_mode_e raw_mode;

   assign raw_mode      = decode_mode(glb_mode, cell_mode);
   assign ctl_pins_free = (glb_mode != 2'b10);

   generate
      if (RESTRICTED) begin : g_restricted
         assign mode = (raw_mode == CM_DED_IN) ? CM_COMB_OUT : raw_mode;
      end else begin : g_full
         assign mode = raw_mode;
      end
   endgenerate
endmodule

// File: rtl/sop_cell_reg.sv
module sop_cell_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic next_level,
   input  logic preload_en,
   input  logic preload_val,
   output logic reg_level
);
   // The flop stores the complement of the pin level, so a cleared
   // flop presents a high pin whatever the polarity.
   logic q;
   logic d;

   assign d = preload_en ? ~preload_val : ~next_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end

   assign reg_level = ~q;
endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
   import sop_cell_pkg::*;
#(
   parameter int NUM_TERMS  = 8,
   parameter bit RESTRICTED = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_TERMS-1:0] pterm,
   input  logic                 oe_n,
   input  logic [1:0]           glb_mode,
   input  logic                 cell_mode,
   input  logic                 out_inv,
   input  logic                 preload_en,
   input  logic                 preload_val,
   input  logic                 pin_in,
   output logic                 pin_out,
   output logic                 pin_oe,
   output logic                 fb,
   output logic                 ctl_pins_free
);
   initial begin
      assert (NUM_TERMS >= MIN_TERMS && NUM_TERMS <= MAX_TERMS)
         else $error("sop_out_cell: NUM_TERMS out of range");
   end

   logic       sum_all, sum_data, en_term;
   logic       lvl_all, lvl_data, reg_level, comb_fb;
   cell_mode_e mode;

   sop_term_sum #(.NUM_TERMS(NUM_TERMS)) i_sum (
      .pterm    (pterm),
      .sum_all  (sum_all),
      .sum_data (sum_data),
      .en_term  (en_term)
   );

   sop_mode_dec #(.RESTRICTED(RESTRICTED)) i_dec (
      .glb_mode      (glb_mode),
      .cell_mode     (cell_mode),
      .mode          (mode),
      .ctl_pins_free (ctl_pins_free)
   );

   assign lvl_all  = sum_all ^ out_inv;
   assign lvl_data = sum_data ^ out_inv;

   sop_cell_reg i_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .next_level  (lvl_all),
      .preload_en  (preload_en),
      .preload_val (preload_val),
      .reg_level   (reg_level)
   );

   generate
      if (RESTRICTED) begin : g_no_fb
         assign comb_fb = 1'b0;
      end else begin : g_fb
         assign comb_fb = lvl_all;
      end
   endgenerate

   always_comb begin
      pin_out = 1'b0;
      pin_oe  = 1'b0;
      fb      = 1'b0;
      unique case (mode)
         CM_REG: begin
            pin_out = reg_level;
            pin_oe  = ~oe_n;
            fb      = reg_level;
         end
         CM_COMB_OUT: begin
            pin_out = lvl_all;
            pin_oe  = 1'b1;
            fb      = comb_fb;
         end
         CM_COMB_IO: begin
            pin_out = lvl_data;
            pin_oe  = en_term;
            fb      = pin_in;
         end
         default: begin
            pin_out = 1'b0;
            pin_oe  = 1'b0;
            fb      = pin_in;
         end
      endcase
   end
endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk #(
   parameter int NUM_TERMS  = 8,
   parameter bit RESTRICTED = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_TERMS-1:0] pterm,
   input logic                 oe_n,
   input logic [1:0]           glb_mode,
   input logic                 cell_mode,
   input logic                 out_inv,
   input logic                 preload_en,
   input logic                 preload_val,
   input logic                 pin_in,
   input logic                 pin_out,
   input logic                 pin_oe,
   input logic                 fb,
   input logic                 ctl_pins_free
);
   logic is_reg, is_cio, is_ded;
   assign is_reg = (glb_mode == 2'b10) && !cell_mode;
   assign is_cio = ((glb_mode == 2'b10) && cell_mode) || ((glb_mode == 2'b11) && !cell_mode);
   assign is_ded = !RESTRICTED && cell_mode && (glb_mode[0] == 1'b1);

   // R1: cleared register shows a high pin
   always @(negedge clk) begin
      if (rst_n === 1'b0 && is_reg)
         a_r1_reset_high: assert (pin_out == 1'b1);
   end

   // R3
   a_r3_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && is_reg && !preload_en) ##1 is_reg |-> pin_out == $past((|pterm) ^ out_inv));

   // R4
   a_r4_reg_drive: assert property (@(posedge clk) disable iff (!rst_n)
      is_reg |-> (pin_oe == !oe_n) && (fb == pin_out));

   // R5
   a_r5_preload: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && preload_en) ##1 is_reg |-> pin_out == $past(preload_val));

   // R7
   a_r7_cio_path: assert property (@(posedge clk) disable iff (!rst_n)
      is_cio |-> (pin_oe == pterm[0]) && (fb == pin_in));

   // R8
   a_r8_ded_in: assert property (@(posedge clk) disable iff (!rst_n)
      is_ded |-> !pin_oe && (fb == pin_in));

   // R10
   a_r10_ctl_free: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_pins_free == (glb_mode != 2'b10));
endmodule

bind sop_out_cell sop_out_cell_chk #(.NUM_TERMS(NUM_TERMS), .RESTRICTED(RESTRICTED)) i_chk (.*);

// File: tb/test_sop_out_cell.sv
module test_sop_out_cell;
   localparam int NT = 8;

   typedef struct packed {
      logic out_a, oe_a, fb_a, out_b, oe_b, fb_b, free;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0] pterm = '0;
   logic oe_n = 1'b0;
   logic [1:0] glb_mode = 2'b10;
   logic cell_mode = 1'b0;
   logic out_inv = 1'b0;
   logic preload_en = 1'b0;
   logic preload_val = 1'b0;
   logic pin_in = 1'b0;
   logic out_a, oe_a, fb_a, free_a;
   logic out_b, oe_b, fb_b, free_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic reg_pin = 1'b1;
   exp_t  exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   sop_out_cell #(.NUM_TERMS(NT), .RESTRICTED(1'b0)) i_sop_out_cell (
      .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_n(oe_n), .glb_mode(glb_mode),
      .cell_mode(cell_mode), .out_inv(out_inv), .preload_en(preload_en),
      .preload_val(preload_val), .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a),
      .fb(fb_a), .ctl_pins_free(free_a));

   sop_out_cell #(.NUM_TERMS(NT), .RESTRICTED(1'b1)) i_sop_out_cell_rst (
      .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_n(oe_n), .glb_mode(glb_mode),
      .cell_mode(cell_mode), .out_inv(out_inv), .preload_en(preload_en),
      .preload_val(preload_val), .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b),
      .fb(fb_b), .ctl_pins_free(free_b));

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // mode per R2 (0 reg, 1 comb out, 2 comb io, 3 ded in); R9 for restricted
   function automatic int mode_of(input logic [1:0] g, input logic l, input bit restr);
      int m;
      if (g == 2'b10)      m = l ? 2 : 0;
      else if (g == 2'b11) m = l ? 3 : 2;
      else if (g == 2'b01) m = l ? 3 : 1;
      else                 m = 1;
      if (restr && m == 3) m = 1;
      return m;
   endfunction

   function automatic logic [2:0] cell_exp(input bit restr);
      logic all_l, data_l;
      all_l  = (|pterm) ^ out_inv;
      data_l = (|pterm[NT-1:1]) ^ out_inv;
      case (mode_of(glb_mode, cell_mode, restr))
         0:       return {reg_pin, ~oe_n, reg_pin};
         1:       return {all_l, 1'b1, restr ? 1'b0 : all_l};
         2:       return {data_l, pterm[0], pin_in};
         default: return {1'b0, 1'b0, pin_in};
      endcase
   endfunction

   task automatic step(input string tag, input logic [1:0] g, input logic l,
                       input logic [NT-1:0] pt, input logic inv, input logic oen,
                       input logic pl_en, input logic pl_v, input logic pin);
      exp_t e;
      logic [2:0] a, b;
      @(negedge clk);
      glb_mode = g; cell_mode = l; pterm = pt; out_inv = inv; oe_n = oen;
      preload_en = pl_en; preload_val = pl_v; pin_in = pin;
      reg_pin = pl_en ? pl_v : ((|pt) ^ inv);
      a = cell_exp(1'b0);
      b = cell_exp(1'b1);
      e = '{a[2], a[1], a[0], b[2], b[1], b[0], (g != 2'b10)};
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({t, " pin_out"},   out_a,  e.out_a);
         check({t, " pin_oe"},    oe_a,   e.oe_a);
         check({t, " fb"},        fb_a,   e.fb_a);
         check({t, " R9 pin_out"}, out_b, e.out_b);
         check({t, " R9 pin_oe"},  oe_b,  e.oe_b);
         check({t, " R9 fb"},      fb_b,  e.fb_b);
         check({t, " R10 free"},   free_a, e.free);
      end
   end

   initial begin
      pterm = '1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 reset active-high", out_a, 1'b1);
      out_inv = 1'b1;
      #1;
      check("R1 reset active-low", out_a, 1'b1);
      check("R1 reset restricted", out_b, 1'b1);
      rst_n = 1'b1;
      step("R3 zero",          2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R3 one term",      2'b10, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R3 active-low",    2'b10, 1'b0, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      step("R4 oe off",        2'b10, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step("R5 preload high",  2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      step("R5 preload low",   2'b10, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      step("R6 comb out",      2'b00, 1'b0, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R6 comb out inv",  2'b01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      step("R7 cio data",      2'b11, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R7 cio term0 only", 2'b10, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      step("R7 cio disabled",  2'b10, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R8 ded in a",      2'b11, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      step("R8 ded in b",      2'b01, 1'b1, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R2 back to reg",   2'b10, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #80000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule